// File: doc/BRIEF.md
# Conservative Load Disambiguation Queue

This block keeps every store that has been decoded but not yet committed, in program order, and decides whether a load may issue ahead of those stores. A store takes a slot at decode and receives an age tag. Its address and its data then arrive later, each on its own port and in either order, addressed by that tag. A load presents the tag the queue would have given the next store at the moment the load was decoded, together with its address. The block answers in the same cycle: the load is granted only when every store older than it has a known address and none of those addresses equals the load's address in the compared low bits.

The comparison uses only the low `PART_W` address bits (12 by default), so two different addresses that agree in those bits count as a conflict. A store with an unknown address always blocks every younger load. Stores leave from the head at commit once both address and data are present, and a flush rewinds the tail to a given tag, dropping that store and every younger one. Forwarding of data, cache access and replay lie outside this block.

Allocation and commit are valid/ready handshakes: a transfer happens in a cycle where both are high. `alloc_ready` depends only on queue occupancy and on `flush_valid`, never on `alloc_valid`; `commit_ready` depends only on the head entry. The requester may hold valid high for any number of cycles without a transfer taking place. Address writes, data writes, flush and the load query are plain strobes.

Top module: `ld_disamb_q`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `commit_ready`=0, `alloc_tag`=0, and a valid load with any tag is granted.
- R2: Each allocation handshake hands out `alloc_tag` and advances it by one (modulo 2^TAGW, the top bit being a wrap bit); after DEPTH (16) live entries `alloc_ready` is 0 and `alloc_tag` does not move while `alloc_valid` is held.
- R3: A valid load is blocked (`ld_grant`=0, `ld_hit`=0) while any store older than its tag has an unknown address.
- R4: A valid load whose low 12 address bits equal those of a known older store gives `ld_hit`=1 and `ld_grant`=0, even when the upper bits differ.
- R5: A valid load is granted when all older stores have known addresses and none matches in the low 12 bits.
- R6: Stores whose tag is equal to or younger than the load's tag, known or not, have no effect on the load result.
- R7: An address written with `sta_valid` is seen by the load check from the next cycle, not in the cycle it is written; a write to a tag that is not live has no effect.
- R8: `commit_ready`=1 only when the head entry is live and both its address and data are known; a commit handshake removes the head, so it no longer affects loads.
- R9: With `flush_valid`, the tail is set to `flush_tag` so that store and all younger ones are dropped; `alloc_tag` equals `flush_tag` the next cycle and `alloc_ready` is 0 in the flush cycle.
- R10: Age ordering stays correct after the slot index wraps past the last entry.
- R11: `ld_grant` and `ld_hit` are 0 whenever `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode wants a store slot |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAGW (5) | Tag given to the store on handshake |
| sta_valid | input | 1 | Store address arrives |
| sta_tag | input | TAGW (5) | Tag of the store receiving its address |
| sta_addr | input | ADDR_W (32) | Store address |
| std_valid | input | 1 | Store data has arrived |
| std_tag | input | TAGW (5) | Tag of the store receiving its data |
| commit_valid | input | 1 | Commit wants to retire the oldest store |
| commit_ready | output | 1 | Head store is complete and may retire |
| flush_valid | input | 1 | Drop stores from `flush_tag` onward |
| flush_tag | input | TAGW (5) | Oldest tag that is dropped |
| ld_valid | input | 1 | Load asks to issue |
| ld_tag | input | TAGW (5) | Store tag current when the load was decoded |
| ld_addr | input | ADDR_W (32) | Load address |
| ld_grant | output | 1 | Load may issue this cycle |
| ld_hit | output | 1 | An older known store matches the load's low bits |

## Verification
The hardest state to reach from the ports is a full queue whose slot indices have wrapped, so that the oldest store lives in a high slot and younger stores sit in low slots with the wrap bit flipped. The stimulus first cycles the pointers through commits and a flush so the head sits mid-array, then fills all sixteen slots, gives each store a distinct address, and probes loads whose tags split the queue on both sides of the wrap point. A partial-address collision with differing upper bits, and an address write landing in the same cycle as the query, are driven from the vector table.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  localparam int unsigned LDQ_DEPTH  = 16;
  localparam int unsigned LDQ_PART_W = 12;
  localparam int unsigned LDQ_ADDR_W = 32;

  typedef struct packed {
    logic addr_ok;
    logic data_ok;
  } ldq_flags_t;
endpackage

// File: rtl/ldq_ptr.sv
module ldq_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned TAGW = IDXW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_fire,
  input  logic                       commit_fire,
  input  logic                       flush_valid,
  input  logic [TAGW-1:0]            flush_tag,
  output logic [TAGW-1:0]            head,
  output logic [TAGW-1:0]            tail,
  output logic [TAGW-1:0]            count,
  output logic [DEPTH-1:0]           live,
  output logic [DEPTH-1:0][IDXW-1:0] off,
  output logic [DEPTH-1:0][TAGW-1:0] slot_tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (commit_fire) head <= head + 1'b1;
      if (flush_valid)     tail <= flush_tag;
      else if (alloc_fire) tail <= tail + 1'b1;
    end
  end

  assign count = tail - head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign off[i]      = IDXW'(i) - head[IDXW-1:0];
    assign live[i]     = {1'b0, off[i]} < count;
    assign slot_tag[i] = head + {1'b0, off[i]};
  end
endmodule

// File: rtl/ldq_entry.sv
module ldq_entry
  import ldq_pkg::*;
#(
  parameter int unsigned PART_W = 12,
  parameter int unsigned TAGW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              take,
  input  logic [TAGW-1:0]   my_tag,
  input  logic              sta_valid,
  input  logic [TAGW-1:0]   sta_tag,
  input  logic [PART_W-1:0] sta_part,
  input  logic              std_valid,
  input  logic [TAGW-1:0]   std_tag,
  output ldq_flags_t        flags,
  output logic [PART_W-1:0] part
);
  logic sta_hit, std_hit;
  assign sta_hit = sta_valid && live && (sta_tag == my_tag);
  assign std_hit = std_valid && live && (std_tag == my_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      part  <= '0;
    end else if (take) begin
      flags <= '0;
    end else begin
      if (sta_hit) begin
        flags.addr_ok <= 1'b1;
        part          <= sta_part;
      end
      if (std_hit) flags.data_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/ldq_check.sv
module ldq_check #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned PART_W = 12,
  localparam int unsigned IDXW  = $clog2(DEPTH),
  localparam int unsigned TAGW  = IDXW + 1
) (
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0][IDXW-1:0]   off,
  input  logic [DEPTH-1:0]             addr_ok,
  input  logic [DEPTH-1:0][PART_W-1:0] part,
  input  logic [TAGW-1:0]              head,
  input  logic                         ld_valid,
  input  logic [TAGW-1:0]              ld_tag,
  input  logic [PART_W-1:0]            ld_part,
  output logic                         ld_grant,
  output logic                         ld_hit
);
  logic [TAGW-1:0]  ld_pos;
  logic [DEPTH-1:0] older, unknown_v, match_v;

  assign ld_pos = ld_tag - head;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign older[i]     = live[i] && ({1'b0, off[i]} < ld_pos);
    assign unknown_v[i] = older[i] && !addr_ok[i];
    assign match_v[i]   = older[i] && addr_ok[i] && (part[i] == ld_part);
  end

  assign ld_hit   = ld_valid && (|match_v);
  assign ld_grant = ld_valid && !(|unknown_v) && !(|match_v);
endmodule

// File: rtl/ld_disamb_q.sv
module ld_disamb_q
  import ldq_pkg::*;
#(
  parameter int unsigned DEPTH  = LDQ_DEPTH,
  parameter int unsigned PART_W = LDQ_PART_W,
  parameter int unsigned ADDR_W = LDQ_ADDR_W,
  localparam int unsigned IDXW  = $clog2(DEPTH),
  localparam int unsigned TAGW  = IDXW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [TAGW-1:0]   alloc_tag,
  input  logic              sta_valid,
  input  logic [TAGW-1:0]   sta_tag,
  input  logic [ADDR_W-1:0] sta_addr,
  input  logic              std_valid,
  input  logic [TAGW-1:0]   std_tag,
  input  logic              commit_valid,
  output logic              commit_ready,
  input  logic              flush_valid,
  input  logic [TAGW-1:0]   flush_tag,
  input  logic              ld_valid,
  input  logic [TAGW-1:0]   ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_grant,
  output logic              ld_hit
);
  logic [TAGW-1:0]               head, tail, count;
  logic [DEPTH-1:0]              live, addr_ok, data_ok;
  logic [DEPTH-1:0][IDXW-1:0]    off;
  logic [DEPTH-1:0][TAGW-1:0]    slot_tag;
  logic [DEPTH-1:0][PART_W-1:0]  part;
  logic                          alloc_fire, commit_fire, full;
  logic [IDXW-1:0]               head_idx;

  assign full         = (count == TAGW'(DEPTH));
  assign alloc_ready  = !full && !flush_valid;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign alloc_tag    = tail;
  assign head_idx     = head[IDXW-1:0];
  assign commit_ready = live[head_idx] && addr_ok[head_idx] && data_ok[head_idx];
  assign commit_fire  = commit_valid && commit_ready;

  ldq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .commit_fire(commit_fire),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .head(head), .tail(tail), .count(count),
    .live(live), .off(off), .slot_tag(slot_tag)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    ldq_flags_t fl;
    ldq_entry #(.PART_W(PART_W), .TAGW(TAGW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .live(live[i]),
      .take(alloc_fire && (tail[IDXW-1:0] == IDXW'(i))),
      .my_tag(slot_tag[i]),
      .sta_valid(sta_valid), .sta_tag(sta_tag), .sta_part(sta_addr[PART_W-1:0]),
      .std_valid(std_valid), .std_tag(std_tag),
      .flags(fl), .part(part[i])
    );
    assign addr_ok[i] = fl.addr_ok;
    assign data_ok[i] = fl.data_ok;
  end

  ldq_check #(.DEPTH(DEPTH), .PART_W(PART_W)) u_chk (
    .live(live), .off(off), .addr_ok(addr_ok), .part(part), .head(head),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_part(ld_addr[PART_W-1:0]),
    .ld_grant(ld_grant), .ld_hit(ld_hit)
  );
endmodule

// File: rtl/ld_disamb_q_sva.sv
module ld_disamb_q_sva #(
  parameter int unsigned TAGW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_valid,
  input logic            alloc_ready,
  input logic [TAGW-1:0] alloc_tag,
  input logic            commit_valid,
  input logic            commit_ready,
  input logic            flush_valid,
  input logic [TAGW-1:0] flush_tag,
  input logic            ld_valid,
  input logic            ld_grant,
  input logic            ld_hit
);
  a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == $past(alloc_tag) + 1'b1));

  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush_valid) |=> $stable(alloc_tag));

  a_r9_flush_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (alloc_tag == $past(flush_tag)));

  a_r9_no_alloc_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !alloc_ready);

  a_r4_hit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> !ld_grant);

  a_r11_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (!ld_grant && !ld_hit));

  a_r8_ready_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ready && !commit_valid && !flush_valid) |=> commit_ready);
endmodule

bind ld_disamb_q ld_disamb_q_sva #(.TAGW(TAGW)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .commit_valid(commit_valid), .commit_ready(commit_ready),
  .flush_valid(flush_valid), .flush_tag(flush_tag),
  .ld_valid(ld_valid), .ld_grant(ld_grant), .ld_hit(ld_hit)
);

// File: tb/tb_ld_disamb_q.sv
`timescale 1ns/1ps
module tb_ld_disamb_q;
  localparam int TAGW = 5;
  localparam time CYC = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, sta_valid = 0, std_valid = 0, commit_valid = 0;
  logic flush_valid = 0, ld_valid = 0;
  logic [TAGW-1:0] sta_tag = 0, std_tag = 0, flush_tag = 0, ld_tag = 0;
  logic [31:0] sta_addr = 0, ld_addr = 0;
  logic alloc_ready, commit_ready, ld_grant, ld_hit;
  logic [TAGW-1:0] alloc_tag;
  int total = 0, bad = 0;

  always #(CYC/2) clk = ~clk;

  ld_disamb_q dut (.*);

  typedef struct packed {
    logic sv; logic [4:0] stag; logic [31:0] saddr;
    logic lv; logic [4:0] ltag; logic [31:0] laddr;
    logic eg; logic eh;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 5'd0, 32'h0,         1'b1, 5'd2, 32'h0000_0100, 1'b0, 1'b0}, // R3
    '{1'b1, 5'd0, 32'h0000_1100, 1'b1, 5'd0, 32'h0000_0100, 1'b1, 1'b0}, // R6
    '{1'b1, 5'd1, 32'h0000_2200, 1'b1, 5'd1, 32'h0000_5100, 1'b0, 1'b1}, // R4
    '{1'b1, 5'd2, 32'h0000_0330, 1'b1, 5'd2, 32'h0000_0444, 1'b1, 1'b0}, // R5
    '{1'b0, 5'd0, 32'h0,         1'b1, 5'd3, 32'h0000_0444, 1'b1, 1'b0}, // R5
    '{1'b0, 5'd0, 32'h0,         1'b1, 5'd4, 32'h0000_0444, 1'b0, 1'b0}, // R3
    '{1'b1, 5'd3, 32'h0000_7444, 1'b1, 5'd4, 32'h0000_0555, 1'b0, 1'b0}, // R7
    '{1'b0, 5'd0, 32'h0,         1'b1, 5'd4, 32'h0000_0555, 1'b1, 1'b0}, // R7
    '{1'b0, 5'd0, 32'h0,         1'b1, 5'd4, 32'h0000_0444, 1'b0, 1'b1}, // R4
    '{1'b0, 5'd0, 32'h0,         1'b1, 5'd3, 32'h0000_0330, 1'b0, 1'b1}, // R4
    '{1'b0, 5'd0, 32'h0,         1'b0, 5'd4, 32'h0000_0444, 1'b0, 1'b0}  // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic alloc_n(input int n);
    for (int k = 0; k < n; k++) begin
      alloc_valid = 1; tick(); alloc_valid = 0;
    end
  endtask

  task automatic set_addr(input logic [4:0] t, input logic [31:0] a);
    sta_valid = 1; sta_tag = t; sta_addr = a; tick(); sta_valid = 0;
  endtask

  task automatic set_data(input logic [4:0] t);
    std_valid = 1; std_tag = t; tick(); std_valid = 0;
  endtask

  task automatic load(input string req, input logic [4:0] t, input logic [31:0] a,
                      input logic eg, input logic eh);
    ld_valid = 1; ld_tag = t; ld_addr = a; #1;
    chk(req, {31'b0, ld_grant}, {31'b0, eg});
    chk(req, {31'b0, ld_hit}, {31'b0, eh});
    ld_valid = 0;
  endtask

  initial begin
    #(CYC * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 alloc_ready", {31'b0, alloc_ready}, 32'd1);
    chk("R1 commit_ready", {31'b0, commit_ready}, 32'd0);
    chk("R1 alloc_tag", {27'b0, alloc_tag}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    load("R1 empty grant", 5'd0, 32'h123, 1'b1, 1'b0);

    alloc_n(4);
    chk("R2 tag step", {27'b0, alloc_tag}, 32'd4);

    foreach (VEC[i]) begin
      sta_valid = VEC[i].sv; sta_tag = VEC[i].stag; sta_addr = VEC[i].saddr;
      ld_valid = VEC[i].lv; ld_tag = VEC[i].ltag; ld_addr = VEC[i].laddr;
      #1;
      chk($sformatf("vec%0d grant", i), {31'b0, ld_grant}, {31'b0, VEC[i].eg});
      chk($sformatf("vec%0d hit", i), {31'b0, ld_hit}, {31'b0, VEC[i].eh});
      tick();
      sta_valid = 0; ld_valid = 0;
    end

    // R7: write to a tag that is not live (tag 9) then allocate up to it
    set_addr(5'd9, 32'h999);
    // R8: commit needs data
    commit_valid = 1; #1;
    chk("R8 no data", {31'b0, commit_ready}, 32'd0);
    commit_valid = 0;
    set_data(5'd0);
    chk("R8 ready", {31'b0, commit_ready}, 32'd1);
    commit_valid = 1; tick(); commit_valid = 0;
    chk("R8 next head no data", {31'b0, commit_ready}, 32'd0);
    set_data(5'd1); set_data(5'd2); set_data(5'd3);
    commit_valid = 1; tick(); commit_valid = 0;
    load("R8 popped heads ignored", 5'd3, 32'h0000_0100, 1'b1, 1'b0);

    // R9: flush
    alloc_n(6);   // tags 4..9
    chk("R2 tag after six", {27'b0, alloc_tag}, 32'd10);
    load("R7 stale write ignored", 5'd10, 32'h999, 1'b0, 1'b0);
    flush_valid = 1; flush_tag = 5'd5; #1;
    chk("R9 ready low", {31'b0, alloc_ready}, 32'd0);
    tick(); flush_valid = 0;
    chk("R9 tail rewound", {27'b0, alloc_tag}, 32'd5);
    set_addr(5'd4, 32'h0000_0AAA);
    load("R9 flushed gone", 5'd9, 32'h0000_0BBB, 1'b1, 1'b0);
    alloc_n(1);   // tag 5 again, address must be unknown
    load("R9 realloc unknown", 5'd6, 32'h0000_0BBB, 1'b0, 1'b0);
    set_addr(5'd5, 32'h0000_0CCC);
    set_data(5'd4); set_data(5'd5);
    for (int k = 0; k < 4; k++) begin
      commit_valid = 1; tick(); commit_valid = 0;
    end
    chk("R8 drained", {31'b0, commit_ready}, 32'd0);

    // R2/R10: fill across the wrap point, head at slot 6
    alloc_n(16);
    chk("R2 full", {31'b0, alloc_ready}, 32'd0);
    chk("R2 tag at full", {27'b0, alloc_tag}, 32'd22);
    alloc_valid = 1; tick(); alloc_valid = 0;
    chk("R2 held while full", {27'b0, alloc_tag}, 32'd22);
    for (int t = 6; t < 22; t++) set_addr(5'(t), 32'h0001_0000 | (t << 4));
    load("R10 all older known", 5'd22, 32'h0000_0FFF, 1'b1, 1'b0);
    load("R10 younger past wrap", 5'd16, 32'h0002_0100, 1'b1, 1'b0);
    load("R10 older past wrap", 5'd17, 32'h0002_0100, 1'b0, 1'b1);
    load("R10 oldest high slot", 5'd7, 32'h0000_0060, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule